// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block watches a byte-wide receive stream and decides, frame by frame, whether a frame is kept. Each byte comes with a valid strobe. The first byte of a frame also carries a start strobe, and the last byte carries an end strobe. The block captures the six-byte destination address and counts the frame length from the first address byte through the last CRC byte. When the frame ends, it reports the verdict on a one-cycle status strobe. The verdict carries an accept bit and three flags: oversize, miss and drop.

Address matching covers three cases:
- one programmed station address for unicast frames;
- a 64-bin hash table for multicast frames;
- the all-ones broadcast address, which can be refused.

A promiscuous setting accepts everything and marks non-matching frames with the miss flag. A receive-while-transmitting guard can suppress frames that start while the transmitter is busy, unless internal loopback is also set. The block treats loopback together with the guard as a configuration error. In that case it does not suppress the frame.

The configuration fields are captured when a frame starts and held until it ends. These are the length limit, broadcast refusal, promiscuous mode, the transmit guard, loopback and hash enable. The station address and the hash table are read live. Runts are frames shorter than the address and are refused. A new frame may start in the same cycle that the previous frame's status is shown.

Top module: `rx_accept_filter`

## Requirements
- R1: A frame opens with a byte that has `rx_valid` and `rx_sof` high while no frame is in progress, and closes with a byte that has `rx_valid` and `rx_eof` high. `stat_valid` is high in the cycle after the clock edge that takes the closing byte, and only then. All status flags and `babble_irq` are low whenever `stat_valid` is low, including after reset.
- R2: The frame length counts every byte from the first destination address byte to the closing byte inclusive, and saturates at 2047. When the length exceeds the held `cfg_max_len`, `stat_oversize` and `babble_irq` are high together for the single status cycle. Neither is raised when the length is equal to or below the limit.
- R3: The first address byte received is compared with `station_addr[47:40]` and the sixth with `station_addr[7:0]`. A unicast address (bit 0 of the first byte clear) equal to `station_addr` is accepted with `stat_miss` low.
- R4: The all-ones address is broadcast. It is accepted when `cfg_bc_reject` is clear. It is refused when `cfg_bc_reject` is set and `cfg_promisc` is clear.
- R5: With `cfg_bc_reject` and `cfg_promisc` both set, a broadcast frame is accepted with `stat_miss` high.
- R6: With `cfg_promisc` set, a frame whose address matches nothing is accepted with `stat_miss` high. With `cfg_promisc` clear, the same frame is refused and `stat_miss` stays low.
- R7: A multicast address has bit 0 of the first byte set and is not all ones. It is accepted when `cfg_hash_en` is set and `mcast_hash[idx]` is 1. The index `idx` is the XOR of the eight 6-bit slices `da[5:0]`, `da[11:6]`, ..., `da[47:42]` of the 48-bit address, where `da[47:40]` is the first byte. Otherwise the frame is refused, unless `cfg_promisc` is set.
- R8: If `cfg_drt` and `tx_busy` are high and `cfg_loopback` is low at the opening byte, the frame is dropped. The status then shows `stat_drop` high with `stat_accept`, `stat_miss`, `stat_oversize` and `babble_irq` low. With `cfg_drt` low, `tx_busy` has no effect.
- R9: If `cfg_drt` and `cfg_loopback` are both high, a frame that opens while `tx_busy` is high is not dropped and is filtered normally.
- R10: Changes to `cfg_promisc`, `cfg_bc_reject` or `tx_busy` after the opening byte do not change the verdict for the current frame.
- R11: A frame that closes before six address bytes have arrived is refused with all flags low. A frame of exactly six bytes is filtered normally.
- R12: An opening byte presented in the same cycle as `stat_valid` starts a new frame, and that frame receives its own status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte strobe |
| rx_sof | input | 1 | Opening byte marker |
| rx_eof | input | 1 | Closing byte marker |
| rx_data | input | 8 | Received byte |
| tx_busy | input | 1 | Transmitter is sending |
| cfg_max_len | input | 11 | Length limit in bytes |
| cfg_bc_reject | input | 1 | Refuse broadcast |
| cfg_promisc | input | 1 | Accept all frames |
| cfg_drt | input | 1 | Suppress receive while transmitting |
| cfg_loopback | input | 1 | Internal loopback selected |
| cfg_hash_en | input | 1 | Use multicast hash table |
| station_addr | input | 48 | Own unicast address |
| mcast_hash | input | 64 | Multicast hash bins |
| stat_valid | output | 1 | Status strobe |
| stat_accept | output | 1 | Frame accepted |
| stat_miss | output | 1 | Accepted without an address match |
| stat_drop | output | 1 | Frame suppressed during transmit |
| stat_oversize | output | 1 | Frame longer than the limit |
| babble_irq | output | 1 | Oversize interrupt pulse |

## Verification
The assertions check the following on every cycle:
- status appears only right after a closing byte;
- flags are silent outside the status strobe;
- a miss always comes with an accept;
- a drop excludes every other flag;
- the oversize interrupt is a single-cycle pulse that coincides with the oversize flag.

Only the directed scenarios can show the address decisions and where the length boundary falls. The same holds for saturation, the runt cut-off, and the fact that configuration is captured at the opening byte.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [2:0] {
        RXF_IDLE,
        RXF_ADDR,
        RXF_BODY,
        RXF_DISCARD,
        RXF_FINISH
    } rxf_state_e;
endpackage

// File: rtl/rxf_addr_capture.sv
module rxf_addr_capture #(
    parameter int DA_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    byte_en,
    input  logic [7:0]              data,
    output logic [8*DA_BYTES-1:0]   da,
    output logic                    da_done
);
    localparam int DA_W  = 8 * DA_BYTES;
    localparam int CNT_W = $clog2(DA_BYTES + 1);

    logic [DA_W-1:0]  da_q;
    logic [CNT_W-1:0] cnt_q;

    // First byte ends up in the top byte once all bytes have shifted in.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            da_q  <= '0;
            cnt_q <= '0;
        end else if (start) begin
            da_q  <= {{(DA_W-8){1'b0}}, data};
            cnt_q <= CNT_W'(1);
        end else if (byte_en && (cnt_q < CNT_W'(DA_BYTES))) begin
            da_q  <= {da_q[DA_W-9:0], data};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign da      = da_q;
    assign da_done = (cnt_q == CNT_W'(DA_BYTES));
endmodule

// File: rtl/rxf_len_counter.sv
module rxf_len_counter #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             byte_en,
    output logic [LEN_W-1:0] len
);
    logic [LEN_W-1:0] len_q;

    // Saturating count: sticks at all ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (start) begin
            len_q <= LEN_W'(1);
        end else if (byte_en && (len_q != '1)) begin
            len_q <= len_q + 1'b1;
        end
    end

    assign len = len_q;
endmodule

// File: rtl/rxf_match.sv
module rxf_match #(
    parameter int DA_BYTES  = 6,
    parameter int HASH_BITS = 6
) (
    input  logic [8*DA_BYTES-1:0]   da,
    input  logic [8*DA_BYTES-1:0]   station,
    input  logic [2**HASH_BITS-1:0] hash_table,
    input  logic                    hash_en,
    input  logic                    bc_reject,
    output logic                    match
);
    localparam int DA_W   = 8 * DA_BYTES;
    localparam int NSLICE = (DA_W + HASH_BITS - 1) / HASH_BITS;
    localparam int PAD_W  = NSLICE * HASH_BITS;

    logic [PAD_W-1:0]     da_pad;
    logic [HASH_BITS-1:0] idx;
    logic                 group_bit, is_bcast, is_mcast, uc_hit, mc_hit;

    assign da_pad = PAD_W'(da);

    always_comb begin
        idx = '0;
        for (int k = 0; k < NSLICE; k++) begin
            idx = idx ^ da_pad[k*HASH_BITS +: HASH_BITS];
        end
    end

    assign group_bit = da[DA_W-8];
    assign is_bcast  = &da;
    assign is_mcast  = group_bit && !is_bcast;
    assign uc_hit    = !group_bit && (da == station);
    assign mc_hit    = is_mcast && hash_en && hash_table[idx];
    assign match     = uc_hit || mc_hit || (is_bcast && !bc_reject);
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter #(
    parameter int LEN_W           = 11,
    parameter int DA_BYTES        = 6,
    parameter int HASH_BITS       = 6,
    parameter int DEFAULT_MAX_LEN = 1518
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic [7:0]              rx_data,
    input  logic                    tx_busy,
    input  logic [LEN_W-1:0]        cfg_max_len,
    input  logic                    cfg_bc_reject,
    input  logic                    cfg_promisc,
    input  logic                    cfg_drt,
    input  logic                    cfg_loopback,
    input  logic                    cfg_hash_en,
    input  logic [8*DA_BYTES-1:0]   station_addr,
    input  logic [2**HASH_BITS-1:0] mcast_hash,
    output logic                    stat_valid,
    output logic                    stat_accept,
    output logic                    stat_miss,
    output logic                    stat_drop,
    output logic                    stat_oversize,
    output logic                    babble_irq
);
    import rxf_pkg::*;

    localparam int DA_W = 8 * DA_BYTES;

    rxf_state_e       state_q, state_nx;
    logic             start, byte_en, drop_now, last_byte;
    logic [DA_W-1:0]  da;
    logic             da_done, match;
    logic [LEN_W-1:0] len;

    logic [LEN_W-1:0] max_q;
    logic             bc_rej_q, promisc_q, hash_en_q, drop_q;

    assign last_byte = rx_valid && rx_eof;
    assign start     = rx_valid && rx_sof &&
                       ((state_q == RXF_IDLE) || (state_q == RXF_FINISH));
    assign byte_en   = rx_valid &&
                       ((state_q == RXF_ADDR) || (state_q == RXF_BODY));
    // Loopback with the guard is a configuration error: never suppress.
    assign drop_now  = cfg_drt && tx_busy && !cfg_loopback;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RXF_IDLE;
        else        state_q <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            RXF_IDLE, RXF_FINISH: begin
                if (start) begin
                    if (rx_eof)        state_nx = RXF_FINISH;
                    else if (drop_now) state_nx = RXF_DISCARD;
                    else               state_nx = RXF_ADDR;
                end else begin
                    state_nx = RXF_IDLE;
                end
            end
            RXF_ADDR: begin
                if (last_byte)    state_nx = RXF_FINISH;
                else if (da_done) state_nx = RXF_BODY;
            end
            RXF_BODY: begin
                if (last_byte) state_nx = RXF_FINISH;
            end
            RXF_DISCARD: begin
                if (last_byte) state_nx = RXF_FINISH;
            end
            default: state_nx = RXF_IDLE;
        endcase
    end

    // Per-frame configuration snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            max_q     <= LEN_W'(DEFAULT_MAX_LEN);
            bc_rej_q  <= 1'b0;
            promisc_q <= 1'b0;
            hash_en_q <= 1'b0;
            drop_q    <= 1'b0;
        end else if (start) begin
            max_q     <= cfg_max_len;
            bc_rej_q  <= cfg_bc_reject;
            promisc_q <= cfg_promisc;
            hash_en_q <= cfg_hash_en;
            drop_q    <= drop_now;
        end
    end

    rxf_addr_capture #(.DA_BYTES(DA_BYTES)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .byte_en (byte_en),
        .data    (rx_data),
        .da      (da),
        .da_done (da_done)
    );

    rxf_len_counter #(.LEN_W(LEN_W)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .byte_en (byte_en),
        .len     (len)
    );

    rxf_match #(.DA_BYTES(DA_BYTES), .HASH_BITS(HASH_BITS)) u_match (
        .da         (da),
        .station    (station_addr),
        .hash_table (mcast_hash),
        .hash_en    (hash_en_q),
        .bc_reject  (bc_rej_q),
        .match      (match)
    );

    // Outputs
    always_comb begin
        logic fin, judged;
        fin           = (state_q == RXF_FINISH);
        judged        = fin && !drop_q && da_done;
        stat_valid    = fin;
        stat_drop     = fin && drop_q;
        stat_accept   = judged && (match || promisc_q);
        stat_miss     = judged && !match && promisc_q;
        stat_oversize = judged && (len > max_q);
        babble_irq    = stat_oversize;
    end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic rx_eof,
    input logic stat_valid,
    input logic stat_accept,
    input logic stat_miss,
    input logic stat_drop,
    input logic stat_oversize,
    input logic babble_irq
);
    AST_STATUS_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> $past(rx_valid && rx_eof)); // R1
    AST_QUIET_OUTSIDE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_valid |-> !(stat_accept || stat_miss || stat_drop || stat_oversize || babble_irq)); // R1
    AST_IRQ_WITH_OVERSIZE: assert property (@(posedge clk) disable iff (!rst_n)
        babble_irq |-> (stat_valid && stat_oversize)); // R2
    AST_IRQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        babble_irq |=> !babble_irq); // R2
    AST_MISS_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        stat_miss |-> stat_accept); // R6
    AST_DROP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_drop |-> !(stat_accept || stat_miss || stat_oversize || babble_irq)); // R8
endmodule

bind rx_accept_filter rxf_checker u_rxf_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_eof        (rx_eof),
    .stat_valid    (stat_valid),
    .stat_accept   (stat_accept),
    .stat_miss     (stat_miss),
    .stat_drop     (stat_drop),
    .stat_oversize (stat_oversize),
    .babble_irq    (babble_irq)
);

// File: tb/rx_accept_filter_bench.sv
module rx_accept_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;
    localparam logic [47:0] OTHER   = 48'h02_AA_BB_CC_DD_EE;
    localparam logic [47:0] BCAST   = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] MCAST   = 48'h01_00_5E_10_20_30;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_valid, rx_sof, rx_eof, tx_busy;
    logic [7:0]  rx_data;
    logic [10:0] cfg_max_len;
    logic        cfg_bc_reject, cfg_promisc, cfg_drt, cfg_loopback, cfg_hash_en;
    logic [47:0] station_addr;
    logic [63:0] mcast_hash;
    logic        stat_valid, stat_accept, stat_miss, stat_drop, stat_oversize, babble_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Mid-frame change controls: bit0 promisc, bit1 bc_reject, bit2 tx_busy
    int       flip_at   = -1;
    bit [2:0] flip_mask = '0;

    // Status captured at the end of each frame
    logic g_valid, g_accept, g_miss, g_drop, g_over, g_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_accept_filter u_rx_accept_filter (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .tx_busy(tx_busy), .cfg_max_len(cfg_max_len), .cfg_bc_reject(cfg_bc_reject),
        .cfg_promisc(cfg_promisc), .cfg_drt(cfg_drt), .cfg_loopback(cfg_loopback),
        .cfg_hash_en(cfg_hash_en), .station_addr(station_addr), .mcast_hash(mcast_hash),
        .stat_valid(stat_valid), .stat_accept(stat_accept), .stat_miss(stat_miss),
        .stat_drop(stat_drop), .stat_oversize(stat_oversize), .babble_irq(babble_irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_status(input string req, input bit acc, input bit miss,
                                input bit drop, input bit over);
        check(req, "stat_valid",    32'(g_valid),  32'd1);
        check(req, "stat_accept",   32'(g_accept), 32'(acc));
        check(req, "stat_miss",     32'(g_miss),   32'(miss));
        check(req, "stat_drop",     32'(g_drop),   32'(drop));
        check(req, "stat_oversize", 32'(g_over),   32'(over));
        check(req, "babble_irq",    32'(g_irq),    32'(over));
    endtask

    function automatic logic [5:0] hash_of(input logic [47:0] a);
        logic [5:0] h = '0;
        for (int k = 0; k < 8; k++) h = h ^ a[k*6 +: 6];
        return h;
    endfunction

    // Called at a falling edge; returns at the falling edge where status is visible.
    task automatic send_frame(input logic [47:0] da, input int len);
        for (int i = 0; i < len; i++) begin
            if (i == flip_at) begin
                if (flip_mask[0]) cfg_promisc   = ~cfg_promisc;
                if (flip_mask[1]) cfg_bc_reject = ~cfg_bc_reject;
                if (flip_mask[2]) tx_busy       = ~tx_busy;
            end
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = (i == len - 1);
            rx_data  = (i < 6) ? da[47 - 8*i -: 8] : 8'(i * 7 + 3);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        g_valid = stat_valid; g_accept = stat_accept; g_miss = stat_miss;
        g_drop  = stat_drop;  g_over   = stat_oversize; g_irq = babble_irq;
        flip_at = -1; flip_mask = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        check("R1", "stat_valid idle", 32'(stat_valid), 32'd0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_data = 0; tx_busy = 0;
        cfg_max_len = 11'd1518; cfg_bc_reject = 0; cfg_promisc = 0; cfg_drt = 0;
        cfg_loopback = 0; cfg_hash_en = 0; station_addr = STATION; mcast_hash = '0;
        repeat (3) @(negedge clk);
        check("R1", "stat_valid in reset", 32'(stat_valid), 32'd0);
        check("R1", "babble_irq in reset", 32'(babble_irq), 32'd0);
        rst_n = 1'b1;
        idle(2);
    endtask

    task automatic t_unicast;
        send_frame(STATION, 64); check_status("R3", 1, 0, 0, 0); idle(1);
        send_frame(OTHER, 64);   check_status("R6", 0, 0, 0, 0); idle(1);
    endtask

    task automatic t_broadcast;
        cfg_bc_reject = 0; send_frame(BCAST, 70); check_status("R4", 1, 0, 0, 0); idle(1);
        cfg_bc_reject = 1; send_frame(BCAST, 70); check_status("R4", 0, 0, 0, 0); idle(1);
        cfg_promisc   = 1; send_frame(BCAST, 70); check_status("R5", 1, 1, 0, 0); idle(1);
        cfg_bc_reject = 0; cfg_promisc = 0;
    endtask

    task automatic t_promisc;
        cfg_promisc = 1;
        send_frame(OTHER, 80);   check_status("R6", 1, 1, 0, 0); idle(1);
        send_frame(STATION, 80); check_status("R6", 1, 0, 0, 0); idle(1);
        cfg_promisc = 0;
    endtask

    task automatic t_multicast;
        logic [5:0] h = hash_of(MCAST);
        cfg_hash_en = 1; mcast_hash = 64'd1 << h;
        send_frame(MCAST, 64); check_status("R7", 1, 0, 0, 0); idle(1);
        mcast_hash = ~(64'd1 << h);
        send_frame(MCAST, 64); check_status("R7", 0, 0, 0, 0); idle(1);
        cfg_hash_en = 0; mcast_hash = 64'd1 << h;
        send_frame(MCAST, 64); check_status("R7", 0, 0, 0, 0); idle(1);
        mcast_hash = '0;
    endtask

    task automatic t_length;
        cfg_max_len = 11'd64;
        send_frame(STATION, 64);   check_status("R2", 1, 0, 0, 0); idle(1);
        send_frame(STATION, 65);   check_status("R2", 1, 0, 0, 1); idle(1);
        cfg_max_len = 11'd1518;
        send_frame(STATION, 1518); check_status("R2", 1, 0, 0, 0); idle(1);
        send_frame(STATION, 1519); check_status("R2", 1, 0, 0, 1); idle(1);
        cfg_max_len = 11'd2047;    // saturation keeps length at 2047, never above
        send_frame(STATION, 2100); check_status("R2", 1, 0, 0, 0); idle(1);
        cfg_max_len = 11'd1518;
    endtask

    task automatic t_drop;
        cfg_drt = 1; tx_busy = 1;
        send_frame(STATION, 1600); check_status("R8", 0, 0, 1, 0); idle(1);
        cfg_drt = 0;
        send_frame(STATION, 64); check_status("R8", 1, 0, 0, 0); idle(1);
        cfg_drt = 1; cfg_loopback = 1;
        send_frame(STATION, 64); check_status("R9", 1, 0, 0, 0); idle(1);
        cfg_loopback = 0; tx_busy = 0; cfg_drt = 0;
    endtask

    task automatic t_hold;
        cfg_promisc = 1; flip_at = 10; flip_mask = 3'b001;
        send_frame(OTHER, 64); check_status("R10", 1, 1, 0, 0); idle(1);
        cfg_bc_reject = 0; flip_at = 10; flip_mask = 3'b010;
        send_frame(BCAST, 64); check_status("R10", 1, 0, 0, 0); idle(1);
        cfg_bc_reject = 0;
        cfg_drt = 1; tx_busy = 1; flip_at = 10; flip_mask = 3'b100;
        send_frame(STATION, 64); check_status("R10", 0, 0, 1, 0); idle(1);
        tx_busy = 0; flip_at = 10; flip_mask = 3'b100;
        send_frame(STATION, 64); check_status("R10", 1, 0, 0, 0); idle(1);
        tx_busy = 0; cfg_drt = 0;
    endtask

    task automatic t_runt;
        cfg_max_len = 11'd2;
        send_frame(STATION, 5); check_status("R11", 0, 0, 0, 0); idle(1);
        send_frame(STATION, 1); check_status("R11", 0, 0, 0, 0); idle(1);
        cfg_max_len = 11'd64;
        send_frame(STATION, 6); check_status("R11", 1, 0, 0, 0); idle(1);
        cfg_max_len = 11'd1518;
    endtask

    task automatic t_back_to_back;
        send_frame(STATION, 64); check_status("R12", 1, 0, 0, 0);
        send_frame(OTHER, 64);   check_status("R12", 0, 0, 0, 0);
        send_frame(BCAST, 64);   check_status("R12", 1, 0, 0, 0); idle(2);
    endtask

    initial begin
        t_reset();
        t_unicast();
        t_broadcast();
        t_promisc();
        t_multicast();
        t_length();
        t_drop();
        t_hold();
        t_runt();
        t_back_to_back();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule